// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives characters framed by a start bit and a stop bit on one serial line that idles high. A free-running divider turns the system clock into an enable strobe at sixteen times the bit rate. The divisor is a run-time input, so software or a neighbouring block can retune the bit rate without a rebuild. For example, a divisor of 521 on a 20 MHz clock gives roughly 2400 bit/s.

The serial input first passes through two synchronizing flops. While the receiver is idle, a falling edge on the synchronized line starts a character. Eight strobes later, at the middle of the start bit, the receiver checks the line again. If the line has gone back high, the event is treated as noise and the receiver returns to idle. Otherwise the receiver samples eight data bits, least significant first, and then the stop bit, with sixteen strobes between samples so that each one lands near the centre of its bit.

When the stop bit is high, the byte is published together with a single-cycle valid strobe. When the stop bit is low, the receiver raises a single-cycle framing-error flag instead, and a saturating counter records the event. A synchronous clear input resets that counter.

Top module: `serial_rx_os`

## Requirements
- R1: The oversampling strobe fires once every D system clocks, where D is the divisor input, so one bit lasts 16*D clocks.
- R2: The serial line passes through two flops. A high-to-low transition on the synchronized line starts a character only while the receiver is idle.
- R3: The line is sampled again 8 strobes after the start edge. If it reads high, the receiver returns to idle and produces neither a byte nor an error.
- R4: Data bits are sampled every 16 strobes after the start check. The first data bit received becomes bit 0 of the byte.
- R5: When the stop bit reads 1, the byte appears on the data output with a valid pulse lasting exactly one clock. The data output holds its value in every other cycle.
- R6: When the stop bit reads 0, the framing-error output pulses for one clock, no valid pulse is issued and the data output keeps its previous byte.
- R7: The error counter (CNT_W bits, 16 by default) rises by one on each framing error and stays at its all-ones value once it gets there.
- R8: The counter clear input sets the counter to 0 on the next clock edge, and it wins over an error in the same cycle.
- R9: After reset the data output, the error counter, the valid pulse and the error pulse are all 0.
- R10: A divisor of 0 behaves exactly like a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W (16) | Clocks per oversampling strobe; 0 acts as 1 |
| line_i | input | 1 | Asynchronous serial input, idle high |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| data_o | output | 8 | Last byte received with a good stop bit |
| valid_o | output | 1 | One-clock pulse when data_o is updated |
| frame_err_o | output | 1 | One-clock pulse on a low stop bit |
| err_cnt_o | output | CNT_W (16) | Saturating count of framing errors |

## Verification
The assertions check, on every cycle, the properties that hold regardless of line traffic. Valid and framing-error pulses last a single clock and never occur together. The data output changes only alongside a valid pulse. The counter is zero after a clear and never wraps to zero on an error.

Only the bench's scenarios can show the timing behaviour: that sampling tracks the divisor (including divisor 0), that a short low glitch is rejected at the mid-start check, that bits are assembled least significant first, and that the counter saturates. The bench checks these against a clock-by-clock behavioural model and against the bytes it transmitted.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
    localparam int OVS  = 16;          // strobes per bit
    localparam int HALF = OVS / 2;     // strobes to mid start bit
    localparam int TC_W = $clog2(OVS);
    localparam int NBITS = 8;
    localparam int BI_W = $clog2(NBITS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        rx_state_e         st;
        logic [TC_W-1:0]   tcnt;
        logic [BI_W-1:0]   bidx;
        logic [NBITS-1:0]  shreg;
        logic [NBITS-1:0]  data;
        logic              valid;
        logic              ferr;
    } rx_regs_t;
endpackage

// File: rtl/rxo_baud.sv
// Free-running divider producing the oversampling strobe (R1, R10).
module rxo_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] last;

    always_comb begin
        eff    = (div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i;   // R10
        last   = eff - {{(DIV_W-1){1'b0}}, 1'b1};
        tick_o = (cnt_q >= last);
        cnt_d  = tick_o ? '0 : cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rxo_sync.sv
// Two-flop synchronizer plus falling-edge detector (R2).
module rxo_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1   = line_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
        line_o   = r_q.s2;
        fall_o   = r_q.prev & ~r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rxo_errcnt.sv
// Saturating framing-error counter with synchronous clear (R7, R8).
module rxo_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;                                            // R8
        else if (inc_i && (cnt_q != {CNT_W{1'b1}}))
            cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};             // R7
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rxo_fsm.sv
// Frame sequencer: start confirm, centre sampling, stop check (R3-R6).
module rxo_fsm
    import rxo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rx_i,
    input  logic             fall_i,
    output logic [NBITS-1:0] data_o,
    output logic             valid_o,
    output logic             ferr_o,
    output logic             ferr_next_o
);
    rx_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.ferr  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (fall_i) begin                                  // R2
                    r_d.st   = ST_START;
                    r_d.tcnt = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (r_q.tcnt == TC_W'(HALF - 1)) begin
                        r_d.tcnt = '0;
                        r_d.bidx = '0;
                        r_d.st   = rx_i ? ST_IDLE : ST_DATA;      // R3
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (r_q.tcnt == TC_W'(OVS - 1)) begin
                        r_d.tcnt  = '0;
                        r_d.shreg = {rx_i, r_q.shreg[NBITS-1:1]};  // R4 LSB first
                        if (r_q.bidx == BI_W'(NBITS - 1))
                            r_d.st = ST_STOP;
                        else
                            r_d.bidx = r_q.bidx + 1'b1;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (r_q.tcnt == TC_W'(OVS - 1)) begin
                        r_d.tcnt = '0;
                        r_d.st   = ST_IDLE;
                        if (rx_i) begin
                            r_d.valid = 1'b1;                      // R5
                            r_d.data  = r_q.shreg;
                        end else begin
                            r_d.ferr  = 1'b1;                      // R6
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        data_o      = r_q.data;
        valid_o     = r_q.valid;
        ferr_o      = r_q.ferr;
        ferr_next_o = r_d.ferr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};            // R9
        else        r_q <= r_d;
    end
endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os
    import rxo_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             line_i,
    input  logic             err_clr_i,
    output logic [7:0]       data_o,
    output logic             valid_o,
    output logic             frame_err_o,
    output logic [CNT_W-1:0] err_cnt_o
);
    logic tick;
    logic rx_s;
    logic fall;
    logic ferr_next;

    rxo_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .tick_o(tick)
    );

    rxo_sync u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_o(rx_s), .fall_o(fall)
    );

    rxo_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s), .fall_i(fall),
        .data_o(data_o), .valid_o(valid_o), .ferr_o(frame_err_o),
        .ferr_next_o(ferr_next)
    );

    rxo_errcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(err_clr_i), .inc_i(ferr_next),
        .cnt_o(err_cnt_o)
    );
endmodule

// File: rtl/rxo_checker.sv
module rxo_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_clr_i,
    input logic [7:0]       data_o,
    input logic             valid_o,
    input logic             frame_err_o,
    input logic [CNT_W-1:0] err_cnt_o
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);                                         // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));                                 // R5
    AST_FERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);                                 // R6
    AST_FERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err_o && valid_o));                                    // R6
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_o && !$past(err_clr_i)) |-> (err_cnt_o != '0));     // R7
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> (err_cnt_o == '0));                              // R8
endmodule

bind serial_rx_os rxo_checker #(.CNT_W(CNT_W)) u_rxo_checker (
    .clk(clk), .rst_n(rst_n), .err_clr_i(err_clr_i), .data_o(data_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o), .err_cnt_o(err_cnt_o)
);

// File: tb/serial_rx_os_bench.sv
module serial_rx_os_bench;
    localparam int PERIOD = 10;
    localparam int DIV_W  = 16;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_i = 16'd4;
    logic             line_i = 1'b1;
    logic             err_clr_i = 1'b0;
    logic [7:0]       data_o;
    logic             valid_o;
    logic             frame_err_o;
    logic [CNT_W-1:0] err_cnt_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int n_valid = 0;

    always #(PERIOD/2) clk = ~clk;

    serial_rx_os #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_serial_rx_os (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .line_i(line_i),
        .err_clr_i(err_clr_i), .data_o(data_o), .valid_o(valid_o),
        .frame_err_o(frame_err_o), .err_cnt_o(err_cnt_o)
    );

    // Behavioural reference model, advanced on every rising edge.
    int m_s1, m_s2, m_prev, m_bc, m_st, m_tc, m_bi, m_sh, m_data, m_cnt;
    int m_valid, m_ferr, m_eff, m_tk, m_fl, m_rx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_bc = 0; m_st = 0; m_tc = 0;
            m_bi = 0; m_sh = 0; m_data = 0; m_cnt = 0; m_valid = 0; m_ferr = 0;
        end else begin
            m_eff = (div_i == 0) ? 1 : int'(div_i);
            m_tk = (m_bc >= m_eff - 1);
            m_fl = (m_prev == 1 && m_s2 == 0);
            m_rx = m_s2;
            m_valid = 0; m_ferr = 0;
            case (m_st)
                0: if (m_fl) begin m_st = 1; m_tc = 0; end
                1: if (m_tk) begin
                       if (m_tc == 7) begin
                           m_tc = 0; m_bi = 0;
                           m_st = (m_rx == 0) ? 2 : 0;
                       end else m_tc++;
                   end
                2: if (m_tk) begin
                       if (m_tc == 15) begin
                           m_sh = (m_sh >> 1) | (m_rx << 7); m_tc = 0;
                           if (m_bi == 7) m_st = 3; else m_bi++;
                       end else m_tc++;
                   end
                default: if (m_tk) begin
                       if (m_tc == 15) begin
                           m_tc = 0; m_st = 0;
                           if (m_rx == 1) begin m_valid = 1; m_data = m_sh; end
                           else m_ferr = 1;
                       end else m_tc++;
                   end
            endcase
            if (err_clr_i) m_cnt = 0;
            else if (m_ferr == 1 && m_cnt < CMAX) m_cnt++;
            m_bc = m_tk ? 0 : m_bc + 1;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(line_i);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) n_valid++;
            check(int'(valid_o) == m_valid, "R5 valid vs model", int'(valid_o), m_valid);
            check(int'(data_o) == m_data, "R4 data vs model", int'(data_o), m_data);
            check(int'(frame_err_o) == m_ferr, "R6 ferr vs model", int'(frame_err_o), m_ferr);
            check(int'(err_cnt_o) == m_cnt, "R7 count vs model", int'(err_cnt_o), m_cnt);
        end
    end

    function automatic int eff_div();
        return (div_i == 0) ? 1 : int'(div_i);
    endfunction

    task automatic hold(input bit v, input int cycles);
        line_i = v;
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit stop);
        int bt;
        bt = 16 * eff_div();
        hold(1'b0, bt);
        for (int i = 0; i < 8; i++) hold(b[i], bt);
        hold(stop, bt);
        hold(1'b1, 4);
    endtask

    task automatic good_frame(input logic [7:0] b, input string req);
        int v0;
        v0 = n_valid;
        send(b, 1'b1);
        check(n_valid == v0 + 1, req, n_valid - v0, 1);
        check(data_o == b, req, int'(data_o), int'(b));
    endtask

    initial begin
        logic [7:0] held;
        int c0;
        int v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(data_o == 8'h00, "R9 data after reset", int'(data_o), 0);
        check(!valid_o && !frame_err_o, "R9 pulses after reset", int'({valid_o, frame_err_o}), 0);
        check(err_cnt_o == '0, "R9 count after reset", int'(err_cnt_o), 0);
        hold(1'b1, 20);

        // R1 R2 R4 R5 at divisor 4
        good_frame(8'hA5, "R4 byte A5 div4");
        good_frame(8'h01, "R4 LSB first 01");
        good_frame(8'h80, "R4 MSB last 80");
        good_frame(8'h00, "R5 byte 00");
        good_frame(8'hFF, "R5 byte FF");

        // R3 short glitch rejected at the mid-start check
        v0 = n_valid; c0 = int'(err_cnt_o); held = data_o;
        hold(1'b0, 3 * eff_div());
        hold(1'b1, 200 * eff_div());
        check(n_valid == v0, "R3 glitch no byte", n_valid - v0, 0);
        check(int'(err_cnt_o) == c0, "R3 glitch no error", int'(err_cnt_o), c0);
        check(data_o == held, "R3 glitch data kept", int'(data_o), int'(held));

        // R6 R7 framing error
        held = data_o; v0 = n_valid; c0 = int'(err_cnt_o);
        send(8'h5A, 1'b0);
        hold(1'b1, 32 * eff_div());
        check(n_valid == v0, "R6 no valid on bad stop", n_valid - v0, 0);
        check(data_o == held, "R6 data kept on bad stop", int'(data_o), int'(held));
        check(int'(err_cnt_o) == c0 + 1, "R7 count incremented", int'(err_cnt_o), c0 + 1);

        // R1 other divisor
        div_i = 16'd7;
        hold(1'b1, 40);
        good_frame(8'h3C, "R1 byte 3C div7");

        // R10 divisor 0 behaves like 1
        div_i = 16'd0;
        hold(1'b1, 40);
        good_frame(8'hC3, "R10 byte C3 div0");
        div_i = 16'd1;
        good_frame(8'h96, "R10 byte 96 div1");

        // R7 saturation
        div_i = 16'd0;
        for (int k = 0; k < CMAX + 3; k++) send(8'h0F, 1'b0);
        hold(1'b1, 40);
        check(int'(err_cnt_o) == CMAX, "R7 saturated", int'(err_cnt_o), CMAX);

        // R8 synchronous clear
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        check(err_cnt_o == '0, "R8 cleared", int'(err_cnt_o), 0);
        good_frame(8'h42, "R5 byte after clear");

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule